// File: doc/BRIEF.md
# Receive FIFO Character Timeout Detector

This block watches the receive queue of a UART working in FIFO mode. It raises a timeout-pending flag when characters are waiting in the queue but nothing has entered or left it for a set stretch of line time. The flag lets the host collect a short tail of data that never reached the queue's trigger level. The block sees only strobes and status: a push strobe, a pop strobe, a queue non-empty flag, a 16x baud tick, the frame format and the FIFO enable. It does not hold the queue, the deserializer or the baud generator.

The idle stretch is four character times. The length of one character comes from the current frame format, so the window follows the line rate and word size rather than the system clock. A read of the receive buffer clears a pending timeout. While the flag is set, the block also presents the interrupt identification code for this interrupt, so the interrupt identification logic can merge it with its other sources.

Top module: `rx_char_timeout`

## Requirements
- R1: After reset, `timeoutPending` is 0 and `intIdCode` is 4'b0000.
- R2: While `fifoEn` is 0, `timeoutPending` stays 0, however long the queue stays idle and non-empty.
- R3: `timeoutPending` rises exactly one cycle after the baud tick that completes the idle window. The window counts ticks with `fifoNonEmpty` high and no push, pop or buffer read. The flag stays 0 after one tick fewer.
- R4: The window is 4 character times. One character is 16 ticks times (1 start + data bits + parity bit if `parityEn` + stop). Data bits are 5 + `wordLen` (2'b00 = 5 … 2'b11 = 8). Stop is 1 bit when `stopTwo` = 0. When `stopTwo` = 1, stop is 1.5 bits with `wordLen` = 2'b00 and 2 bits otherwise.
- R5: A `fifoPush` pulse restarts the idle window from zero.
- R6: A `fifoPop` pulse restarts the idle window from zero.
- R7: While `fifoNonEmpty` is 0 the window is held at zero. A full window is needed after the queue becomes non-empty.
- R8: An `rbrRead` pulse clears `timeoutPending` at the next edge and restarts the window.
- R9: Once set, `timeoutPending` stays 1 through further ticks and through push or pop pulses, until a buffer read, a format change or `fifoEn` going low.
- R10: Any change of `wordLen`, `parityEn`, `stopTwo` or `fifoEn` clears `timeoutPending` at the next edge and restarts the window. The new window length applies from then on.
- R11: `intIdCode` is 4'b1100 while `timeoutPending` is 1, and 4'b0000 otherwise.
- R12: Only cycles with `baudTick` high advance the window. Clock cycles without a tick do not count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fifoEn | input | 1 | FIFO mode enable |
| wordLen | input | 2 | Data bits minus five |
| parityEn | input | 1 | Parity bit present in frame |
| stopTwo | input | 1 | Long stop selection (1.5 or 2 bits) |
| baudTick | input | 1 | 16x oversampling tick |
| fifoPush | input | 1 | Character written into receive queue |
| fifoPop | input | 1 | Character removed from receive queue |
| fifoNonEmpty | input | 1 | Receive queue holds at least one character |
| rbrRead | input | 1 | Host read of the receive buffer |
| timeoutPending | output | 1 | Character timeout pending |
| intIdCode | output | 4 | Identification code for this interrupt |

## Verification
A wrong idle count, or a stale length, shows at the ports as a flag that rises a cycle early or late relative to the last tick of the window. The bench pins this down by checking one tick before the window closes and again at the closing tick, across four frame formats. A restart that is lost on push, pop, read, empty or format change makes the flag rise within one window of the missed event. A flag that is not held until it is cleared shows on the first cycle after the hold is broken.

// File: rtl/rct_pkg.sv
package rct_pkg;

  typedef struct packed {
    logic [1:0] wordLen;
    logic       parityEn;
    logic       stopTwo;
  } rctFormat_t;

  typedef struct packed {
    logic restart;
    logic advance;
  } rctStrobe_t;

  // Length of one character in half-bit units
  function automatic int unsigned halfBitsPerChar(rctFormat_t f);
    int unsigned bits;
    int unsigned stopHalves;
    bits = 1 + 5 + int'(f.wordLen) + (f.parityEn ? 1 : 0);
    if (!f.stopTwo)              stopHalves = 2;
    else if (f.wordLen == 2'b00) stopHalves = 3;
    else                         stopHalves = 4;
    return 2 * bits + stopHalves;
  endfunction

endpackage

// File: rtl/rct_datapath.sv
module rct_datapath
  import rct_pkg::*;
#(
  parameter int OVERSAMPLE  = 16,
  parameter int CHAR_WINDOW = 4,
  parameter int CNT_W       = 10
) (
  input  logic       clk,
  input  logic       rstN,
  input  rctFormat_t format,
  input  rctStrobe_t strb,
  output logic       windowDone
);

  localparam int HALF_TICKS = OVERSAMPLE / 2;

  logic [CNT_W-1:0] idleCnt;
  logic [CNT_W-1:0] limit;

  always_comb begin
    limit      = CNT_W'(halfBitsPerChar(format) * HALF_TICKS * CHAR_WINDOW);
    windowDone = (idleCnt == limit - CNT_W'(1));
  end

  always_ff @(posedge clk) begin
    if (!rstN)             idleCnt <= '0;
    else if (strb.restart) idleCnt <= '0;
    else if (strb.advance && !windowDone) idleCnt <= idleCnt + CNT_W'(1);
  end

  p_restart_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.restart |=> (idleCnt == '0));

  p_cnt_in_window_r4: assert property (@(posedge clk) disable iff (!rstN)
    !strb.restart |-> (idleCnt < limit));

  p_hold_without_tick_r12: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.advance && !strb.restart) |=> $stable(idleCnt));

endmodule

// File: rtl/rct_ctrl.sv
module rct_ctrl
  import rct_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       fifoEn,
  input  rctFormat_t format,
  input  logic       baudTick,
  input  logic       fifoPush,
  input  logic       fifoPop,
  input  logic       fifoNonEmpty,
  input  logic       rbrRead,
  input  logic       windowDone,
  output rctStrobe_t strb,
  output logic       timeoutPending
);

  logic       fifoEnQ;
  rctFormat_t formatQ;
  logic       cfgChange;
  logic       clearReq;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fifoEnQ <= 1'b0;
      formatQ <= '0;
    end else begin
      fifoEnQ <= fifoEn;
      formatQ <= format;
    end
  end

  always_comb begin
    cfgChange    = (fifoEn != fifoEnQ) || (format != formatQ);
    clearReq     = !fifoEn || cfgChange || rbrRead;
    strb.restart = fifoPush || fifoPop || !fifoNonEmpty || clearReq;
    strb.advance = baudTick && !strb.restart && !timeoutPending;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                               timeoutPending <= 1'b0;
    else if (clearReq)                       timeoutPending <= 1'b0;
    else if (strb.advance && windowDone)     timeoutPending <= 1'b1;
  end

  p_off_when_disabled_r2: assert property (@(posedge clk) disable iff (!rstN)
    !fifoEn |=> !timeoutPending);

  p_rise_needs_idle_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timeoutPending) |-> $past(baudTick && fifoNonEmpty && !fifoPush && !fifoPop && !rbrRead));

  p_read_clears_r8: assert property (@(posedge clk) disable iff (!rstN)
    rbrRead |=> !timeoutPending);

  p_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    (timeoutPending && !clearReq) |=> timeoutPending);

  p_cfg_clears_r10: assert property (@(posedge clk) disable iff (!rstN)
    cfgChange |=> !timeoutPending);

endmodule

// File: rtl/rx_char_timeout.sv
module rx_char_timeout
  import rct_pkg::*;
#(
  parameter int OVERSAMPLE  = 16,
  parameter int CHAR_WINDOW = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       fifoEn,
  input  logic [1:0] wordLen,
  input  logic       parityEn,
  input  logic       stopTwo,
  input  logic       baudTick,
  input  logic       fifoPush,
  input  logic       fifoPop,
  input  logic       fifoNonEmpty,
  input  logic       rbrRead,
  output logic       timeoutPending,
  output logic [3:0] intIdCode
);

  localparam int MAX_HALF_BITS = 24;
  localparam int MAX_WINDOW    = MAX_HALF_BITS * (OVERSAMPLE / 2) * CHAR_WINDOW;
  localparam int CNT_W         = $clog2(MAX_WINDOW + 1);
  localparam logic [3:0] TIMEOUT_CODE = 4'b1100;

  rctFormat_t format;
  rctStrobe_t strb;
  logic       windowDone;

  assign format = '{wordLen: wordLen, parityEn: parityEn, stopTwo: stopTwo};

  rct_ctrl u_ctrl (
    .clk            (clk),
    .rstN           (rstN),
    .fifoEn         (fifoEn),
    .format         (format),
    .baudTick       (baudTick),
    .fifoPush       (fifoPush),
    .fifoPop        (fifoPop),
    .fifoNonEmpty   (fifoNonEmpty),
    .rbrRead        (rbrRead),
    .windowDone     (windowDone),
    .strb           (strb),
    .timeoutPending (timeoutPending)
  );

  rct_datapath #(
    .OVERSAMPLE  (OVERSAMPLE),
    .CHAR_WINDOW (CHAR_WINDOW),
    .CNT_W       (CNT_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .format     (format),
    .strb       (strb),
    .windowDone (windowDone)
  );

  assign intIdCode = timeoutPending ? TIMEOUT_CODE : 4'b0000;

endmodule

// File: tb/sim_rx_char_timeout.sv
module sim_rx_char_timeout;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       fifoEn = 1'b0;
  logic [1:0] wordLen = 2'b00;
  logic       parityEn = 1'b0;
  logic       stopTwo = 1'b0;
  logic       baudTick = 1'b0;
  logic       fifoPush = 1'b0;
  logic       fifoPop = 1'b0;
  logic       fifoNonEmpty = 1'b0;
  logic       rbrRead = 1'b0;
  logic       timeoutPending;
  logic [3:0] intIdCode;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  rx_char_timeout u0 (
    .clk(clk), .rstN(rstN), .fifoEn(fifoEn), .wordLen(wordLen),
    .parityEn(parityEn), .stopTwo(stopTwo), .baudTick(baudTick),
    .fifoPush(fifoPush), .fifoPop(fifoPop), .fifoNonEmpty(fifoNonEmpty),
    .rbrRead(rbrRead), .timeoutPending(timeoutPending), .intIdCode(intIdCode)
  );

  task automatic check(input string req, input logic [3:0] got, input logic [3:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  // Window length in ticks, worked out from the requirement text
  function automatic int windowTicks(input logic [1:0] wl, input logic par, input logic st);
    int stopT;
    if (!st)             stopT = 16;
    else if (wl == 2'b00) stopT = 24;
    else                 stopT = 32;
    return 4 * (16 * (1 + 5 + int'(wl) + (par ? 1 : 0)) + stopT);
  endfunction

  task automatic ticks(input int n);
    baudTick = 1'b1;
    repeat (n) @(negedge clk);
    baudTick = 1'b0;
  endtask

  task automatic pulsePush();
    fifoPush = 1'b1; @(negedge clk); fifoPush = 1'b0;
  endtask

  task automatic pulsePop();
    fifoPop = 1'b1; @(negedge clk); fifoPop = 1'b0;
  endtask

  task automatic pulseRead();
    rbrRead = 1'b1; @(negedge clk); rbrRead = 1'b0;
  endtask

  task automatic setFormat(input logic [1:0] wl, input logic par, input logic st);
    wordLen = wl; parityEn = par; stopTwo = st;
    repeat (2) @(negedge clk);
  endtask

  task automatic testReset();
    check("R1 pending", {3'b0, timeoutPending}, 4'b0000);
    check("R1 code", intIdCode, 4'b0000);
  endtask

  task automatic testDisabled();
    fifoEn = 1'b0; fifoNonEmpty = 1'b1;
    repeat (2) @(negedge clk);
    ticks(2000);
    check("R2 no flag when disabled", {3'b0, timeoutPending}, 4'b0000);
    check("R2 code", intIdCode, 4'b0000);
    fifoEn = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic testFormat(input logic [1:0] wl, input logic par, input logic st);
    int n;
    n = windowTicks(wl, par, st);
    setFormat(wl, par, st);
    pulsePop();
    ticks(n - 1);
    check("R4 one tick short", {3'b0, timeoutPending}, 4'b0000);
    ticks(1);
    check("R3 exact window", {3'b0, timeoutPending}, 4'b0001);
    check("R11 code pending", intIdCode, 4'b1100);
    pulseRead();
    check("R8 read clears", {3'b0, timeoutPending}, 4'b0000);
    check("R11 code idle", intIdCode, 4'b0000);
  endtask

  task automatic testPushRestart();
    setFormat(2'b00, 1'b0, 1'b0);
    pulsePop();
    ticks(400);
    pulsePush();
    ticks(447);
    check("R5 push restarts", {3'b0, timeoutPending}, 4'b0000);
    ticks(1);
    check("R5 full window after push", {3'b0, timeoutPending}, 4'b0001);
    pulseRead();
  endtask

  task automatic testPopRestart();
    pulsePop();
    ticks(300);
    pulsePop();
    ticks(447);
    check("R6 pop restarts", {3'b0, timeoutPending}, 4'b0000);
    ticks(1);
    check("R6 full window after pop", {3'b0, timeoutPending}, 4'b0001);
    pulseRead();
  endtask

  task automatic testEmptyHold();
    fifoNonEmpty = 1'b0;
    ticks(600);
    check("R7 empty never flags", {3'b0, timeoutPending}, 4'b0000);
    fifoNonEmpty = 1'b1;
    ticks(447);
    check("R7 window from non-empty", {3'b0, timeoutPending}, 4'b0000);
    ticks(1);
    check("R7 flag after full window", {3'b0, timeoutPending}, 4'b0001);
    pulseRead();
  endtask

  task automatic testSticky();
    pulsePop();
    ticks(448);
    check("R9 set", {3'b0, timeoutPending}, 4'b0001);
    ticks(1000);
    check("R9 held over ticks", {3'b0, timeoutPending}, 4'b0001);
    pulsePush();
    pulsePop();
    check("R9 held over push/pop", {3'b0, timeoutPending}, 4'b0001);
    pulseRead();
    check("R8 cleared by read", {3'b0, timeoutPending}, 4'b0000);
    ticks(447);
    check("R8 read restarts window", {3'b0, timeoutPending}, 4'b0000);
    ticks(1);
    check("R8 flag after window from read", {3'b0, timeoutPending}, 4'b0001);
    pulseRead();
  endtask

  task automatic testCfgChange();
    int n;
    pulsePop();
    ticks(448);
    check("R10 pre set", {3'b0, timeoutPending}, 4'b0001);
    parityEn = 1'b1;
    @(negedge clk);
    check("R10 format change clears", {3'b0, timeoutPending}, 4'b0000);
    n = windowTicks(2'b00, 1'b1, 1'b0);
    ticks(n - 1);
    check("R10 new length short", {3'b0, timeoutPending}, 4'b0000);
    ticks(1);
    check("R10 new length exact", {3'b0, timeoutPending}, 4'b0001);
    fifoEn = 1'b0;
    @(negedge clk);
    check("R10 disable clears", {3'b0, timeoutPending}, 4'b0000);
    fifoEn = 1'b1;
    setFormat(2'b00, 1'b0, 1'b0);
  endtask

  task automatic testSparseTicks();
    pulsePop();
    for (int i = 0; i < 447; i++) begin
      baudTick = 1'b1; @(negedge clk);
      baudTick = 1'b0; repeat (2) @(negedge clk);
    end
    check("R12 cycles without tick ignored", {3'b0, timeoutPending}, 4'b0000);
    baudTick = 1'b1; @(negedge clk); baudTick = 1'b0;
    check("R12 flag on last tick", {3'b0, timeoutPending}, 4'b0001);
    pulseRead();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testDisabled();
    testFormat(2'b00, 1'b0, 1'b0);
    testFormat(2'b00, 1'b0, 1'b1);
    testFormat(2'b11, 1'b1, 1'b1);
    testFormat(2'b10, 1'b1, 1'b0);
    fifoNonEmpty = 1'b1;
    testPushRestart();
    testPopRestart();
    testEmptyHold();
    testSticky();
    testCfgChange();
    testSparseTicks();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule